// File: doc/BRIEF.md
# Phase-Change Array Write Pulse Sequencer

This block takes one wide write word from a host over a valid/ready handshake and latches it into an internal holding register. Once the word is held, it drives one pair of programming strobes per bit toward a phase-change cell array. Every bit gets exactly one of two enable windows. A one bit gets a long, moderate-power crystallizing window on its SET strobe. A zero bit gets a short melt window on its RESET strobe. Every window opens in the same clock cycle.

The two window lengths are parameters counted in clock cycles. The write is finished only when the longer SET window has closed. At that point a one-cycle done pulse is raised, and the host side becomes ready again in the following cycle. A request presented while the block is busy is held off by a low ready and is taken once ready returns. The analog pulse shape is represented only by the length of each enable window.

Top module: `pcm_wr_pulse_ctrl`

## Requirements
- R1: A data bit of value 1 raises its `set_en` bit in the first cycle after the accepting clock edge and keeps it high for exactly `SET_CYC` cycles.
- R2: A data bit of value 0 raises its `reset_en` bit in the first cycle after the accepting clock edge, keeps it high for exactly `RST_CYC` cycles, and holds it low for the rest of the write.
- R3: No bit ever has `reset_en` and `set_en` high together. Every enable is low while the block is idle and during the done cycle.
- R4: `done` is high for exactly one cycle, which is cycle number `SET_CYC` after the accepting edge, counting the first pulse cycle as cycle 0. This is the cycle right after the last SET cycle.
- R5: `wr_ready` is low from the accepting edge through the done cycle and is high again in the cycle after done. `busy` is always the inverse of `wr_ready`.
- R6: A request held valid while the block is busy is neither taken nor lost. It is taken at the first edge where `wr_ready` is high, and each taken word produces exactly one write.
- R7: The word is captured at the accepting edge. Changes on `wr_data` after that edge have no effect on the enables of the write in progress.
- R8: While `rst_n` is low at a clock edge, all enables and `done` go low after that edge, `wr_ready` goes high, and the write in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | Host presents a write word |
| wr_ready | output | 1 | Block can take a word at this edge |
| wr_data | input | DATA_W | Write word; bit i selects the pulse type for cell i |
| busy | output | 1 | A write is in progress |
| done | output | 1 | One-cycle completion pulse |
| reset_en | output | DATA_W | Per-bit melt (store 0) strobe |
| set_en | output | DATA_W | Per-bit crystallize (store 1) strobe |

## Verification
The accepting edge is the edge at which `wr_valid` and `wr_ready` are both high. Counting from that edge, the enables become visible in cycle 0. RESET strobes close after `RST_CYC` cycles and SET strobes after `SET_CYC` cycles. `done` is due in cycle `SET_CYC` and `wr_ready` in cycle `SET_CYC`+1. The scoreboard monitor samples one nanosecond after each falling edge, where every output of the previous rising edge has settled. It detects the accepting edge from the handshake it sees in that same sample and then steps a cycle index through those exact due cycles. Each sampled cycle is compared against the value the queued word predicts.

// File: rtl/pcm_wr_pkg.sv
package pcm_wr_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_PULSE = 2'd1,
      PH_DONE  = 2'd2
   } wr_phase_t;

   function automatic int cnt_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/pcm_wr_hold_reg.sv
module pcm_wr_hold_reg #(
   parameter int DATA_W = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= '0;
      else if (load)
         q <= d;
   end

endmodule

// File: rtl/pcm_wr_window_seq.sv
module pcm_wr_window_seq
   import pcm_wr_pkg::*;
#(
   parameter int RST_CYC = 4,
   parameter int SET_CYC = 10
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   output wr_phase_t phase,
   output logic      melt_win,
   output logic      xtal_win
);

   localparam int CNT_W = cnt_width(SET_CYC);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SET_CYC - 1);

   wr_phase_t        ph_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         cnt_q <= '0;
      end else begin
         unique case (ph_q)
            PH_IDLE: begin
               cnt_q <= '0;
               if (start)
                  ph_q <= PH_PULSE;
            end
            PH_PULSE: begin
               if (cnt_q == LAST_CNT) begin
                  ph_q  <= PH_DONE;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PH_DONE: ph_q <= PH_IDLE;
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign phase    = ph_q;
   assign xtal_win = (ph_q == PH_PULSE);

   generate
      if (RST_CYC == SET_CYC) begin : g_equal_len
         assign melt_win = xtal_win;
      end else begin : g_short_melt
         localparam logic [CNT_W-1:0] MELT_END = CNT_W'(RST_CYC);
         assign melt_win = xtal_win && (cnt_q < MELT_END);
      end
   endgenerate

endmodule

// File: rtl/pcm_wr_lane_drv.sv
module pcm_wr_lane_drv #(
   parameter int DATA_W = 128
) (
   input  logic              melt_win,
   input  logic              xtal_win,
   input  logic [DATA_W-1:0] held,
   output logic [DATA_W-1:0] reset_en,
   output logic [DATA_W-1:0] set_en
);

   for (genvar i = 0; i < DATA_W; i++) begin : g_lane
      assign set_en[i]   = xtal_win & held[i];
      assign reset_en[i] = melt_win & ~held[i];
   end

endmodule

// File: rtl/pcm_wr_pulse_ctrl.sv
module pcm_wr_pulse_ctrl
   import pcm_wr_pkg::*;
#(
   parameter int DATA_W  = 128,
   parameter int RST_CYC = 4,
   parameter int SET_CYC = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   output logic              wr_ready,
   input  logic [DATA_W-1:0] wr_data,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] reset_en,
   output logic [DATA_W-1:0] set_en
);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("pcm_wr_pulse_ctrl: DATA_W must be at least 1");
      end
      if (RST_CYC < 1) begin : g_bad_melt
         $error("pcm_wr_pulse_ctrl: RST_CYC must be at least 1");
      end
      if (SET_CYC < RST_CYC) begin : g_bad_xtal
         $error("pcm_wr_pulse_ctrl: SET_CYC must not be shorter than RST_CYC");
      end
   endgenerate

   wr_phase_t         phase;
   logic              melt_win;
   logic              xtal_win;
   logic              take;
   logic [DATA_W-1:0] held;

   assign wr_ready = (phase == PH_IDLE);
   assign busy     = ~wr_ready;
   assign done     = (phase == PH_DONE);
   assign take     = wr_valid & wr_ready;

   pcm_wr_hold_reg #(.DATA_W(DATA_W)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (take),
      .d     (wr_data),
      .q     (held)
   );

   pcm_wr_window_seq #(.RST_CYC(RST_CYC), .SET_CYC(SET_CYC)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (take),
      .phase    (phase),
      .melt_win (melt_win),
      .xtal_win (xtal_win)
   );

   pcm_wr_lane_drv #(.DATA_W(DATA_W)) u_lanes (
      .melt_win (melt_win),
      .xtal_win (xtal_win),
      .held     (held),
      .reset_en (reset_en),
      .set_en   (set_en)
   );

endmodule

// File: rtl/pcm_wr_pulse_chk.sv
module pcm_wr_pulse_chk #(
   parameter int DATA_W  = 128,
   parameter int SET_CYC = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_valid,
   input logic              wr_ready,
   input logic              busy,
   input logic              done,
   input logic [DATA_W-1:0] reset_en,
   input logic [DATA_W-1:0] set_en
);

   localparam int CW = $clog2(SET_CYC + 2);

   logic          act;
   logic [CW-1:0] seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act  <= 1'b0;
         seen <= '0;
      end else if (wr_valid && wr_ready) begin
         act  <= 1'b1;
         seen <= '0;
      end else if (done) begin
         act  <= 1'b0;
      end else if (act) begin
         seen <= seen + 1'b1;
      end
   end

   p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reset_en & set_en) == '0);

   p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ready || done) |-> ((reset_en | set_en) == '0));

   p_busy_inv_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy == !wr_ready);

   p_take_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_ready) |=> !wr_ready);

   p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_ready_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> wr_ready);

   p_done_time_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (act && seen == CW'(SET_CYC)));

endmodule

bind pcm_wr_pulse_ctrl pcm_wr_pulse_chk #(.DATA_W(DATA_W), .SET_CYC(SET_CYC)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_valid (wr_valid),
   .wr_ready (wr_ready),
   .busy     (busy),
   .done     (done),
   .reset_en (reset_en),
   .set_en   (set_en)
);

// File: tb/pcm_wr_pulse_ctrl_test.sv
module pcm_wr_pulse_ctrl_test;

   localparam int W   = 128;
   localparam int RST = 4;
   localparam int SET = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_valid = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic         wr_ready;
   logic         busy;
   logic         done;
   logic [W-1:0] reset_en;
   logic [W-1:0] set_en;

   int n_cmp = 0;
   int n_bad = 0;
   bit mon_on = 1'b0;
   logic [W-1:0] exp_q[$];

   always #2 clk = ~clk;

   pcm_wr_pulse_ctrl #(.DATA_W(W), .RST_CYC(RST), .SET_CYC(SET)) uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_valid (wr_valid),
      .wr_ready (wr_ready),
      .wr_data  (wr_data),
      .busy     (busy),
      .done     (done),
      .reset_en (reset_en),
      .set_en   (set_en)
   );

   task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
      end
   endtask

   // Driver: push the expected word, then hold valid until it is taken
   task automatic send(input logic [W-1:0] d);
      wr_valid = 1'b1;
      wr_data  = d;
      exp_q.push_back(d);
      forever begin
         #1;
         if (wr_ready) break;
         @(negedge clk);
      end
      @(negedge clk);
      wr_valid = 1'b0;
      wr_data  = ~d;   // R7: disturb the input bus after capture
   endtask

   // Monitor / scoreboard
   initial begin
      int k;
      logic [W-1:0] cur;
      k = -1;
      cur = '0;
      forever begin
         @(negedge clk);
         #1;
         if (!mon_on) begin
            k = -1;
         end else begin
            if (k >= 0 && k < SET) begin
               chk(set_en == cur, "R1 set window", set_en, cur);
               chk(reset_en == ((k < RST) ? ~cur : '0), "R2 reset window", reset_en, (k < RST) ? ~cur : '0);
               chk(!done && !wr_ready && busy, "R5 busy during pulse", {done, wr_ready, busy}, 3'b001);
               if (k == 1 && wr_data != cur)
                  chk(set_en == cur, "R7 capture", set_en, cur);
               k++;
            end else if (k == SET) begin
               chk(done == 1'b1, "R4 done due", done, 1);
               chk((reset_en | set_en) == '0, "R3 quiet at done", reset_en | set_en, '0);
               chk(!wr_ready, "R5 ready low at done", wr_ready, 0);
               k++;
            end else if (k == SET + 1) begin
               chk(wr_ready && !busy && !done, "R5 ready after done", {wr_ready, busy, done}, 3'b100);
               chk((reset_en | set_en) == '0, "R3 idle quiet", reset_en | set_en, '0);
               k = -1;
            end else begin
               chk(!done && ((reset_en | set_en) == '0), "R3 idle quiet", {done, reset_en | set_en}, '0);
            end
            if (wr_valid && wr_ready) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R6 unexpected take", 1, 0);
               end else begin
                  cur = exp_q.pop_front();
                  k = 0;
               end
            end
         end
      end
   end

   // Watchdog
   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk(wr_ready && !busy && !done, "R8 reset state", {wr_ready, busy, done}, 3'b100);
      chk((reset_en | set_en) == '0, "R8 reset enables", reset_en | set_en, '0);
      @(negedge clk);
      rst_n  = 1'b1;
      mon_on = 1'b1;
      @(negedge clk);

      send({W{1'b0}});
      repeat (SET + 3) @(negedge clk);
      send({W{1'b1}});
      repeat (SET + 3) @(negedge clk);
      send({(W/2){2'b01}});
      repeat (SET + 3) @(negedge clk);
      send({(W/2){2'b10}});
      repeat (SET + 3) @(negedge clk);

      // R6: back-to-back requests held off during busy
      send({4{32'hDEAD_BEEF}});
      send(W'(1) << 77);
      send({4{32'h0F0F_3C96}});
      repeat (SET + 3) @(negedge clk);
      chk(exp_q.size() == 0, "R6 every word taken", W'(exp_q.size()), '0);

      // R8: reset in the middle of a write
      send({(W/4){4'b1001}});
      repeat (3) @(negedge clk);
      mon_on = 1'b0;
      rst_n  = 1'b0;
      @(negedge clk);
      #1;
      chk((reset_en | set_en) == '0, "R8 reset mid-write enables", reset_en | set_en, '0);
      chk(wr_ready && !done && !busy, "R8 reset mid-write ready", {wr_ready, done, busy}, 3'b100);
      exp_q.delete();
      @(negedge clk);
      rst_n  = 1'b1;
      mon_on = 1'b1;
      @(negedge clk);
      send({2{64'h1234_5678_9ABC_DEF0}});
      repeat (SET + 3) @(negedge clk);
      chk(exp_q.size() == 0, "R6 queue drained", W'(exp_q.size()), '0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule